// File: doc/BRIEF.md
# Floating-Point Minimum, Maximum and Comparison Unit

This block takes two IEEE-754 double-precision operands and a three-bit operation code. It either picks one of the operands (or the canonical NaN) as a minimum or maximum, or it produces a single-bit ordered comparison result. In both cases it also produces a five-bit exception-flag vector.

There are two min/max families and two compare families. The ordinary min/max forms drop a single NaN operand and return the other operand. The NaN-propagating forms return the canonical NaN as soon as either operand is a NaN. Likewise, the ordinary less-than and less-or-equal forms treat every NaN as invalid, while their quiet counterparts complain only about signaling NaNs.

The operation logic is purely combinational. A parameter selects whether one output register sits in front of the ports. By default the register is present, and the outputs then reflect the inputs one clock later.

Top module: `fpmm_unit`

## Requirements
- R1: `opSel` encodes 0 = min, 1 = max, 2 = NaN-propagating min, 3 = NaN-propagating max, 4 = less-than, 5 = less-or-equal, 6 = quiet less-than, 7 = quiet less-or-equal. For non-NaN operands, min returns the smaller operand and max returns the larger one, with -0.0 ordered below +0.0.
- R2: Ordinary min/max (codes 0, 1) return the other operand when exactly one operand is a NaN. They return 0x7FF8000000000000 when both operands are NaN.
- R3: NaN-propagating min/max (codes 2, 3) return 0x7FF8000000000000 whenever either operand is a NaN. Otherwise they match codes 0 and 1.
- R4: Compare codes 4 to 7 drive the result on `resCmp` and drive `resData` to zero. Min/max codes drive `resCmp` to zero. In comparisons, +0.0 and -0.0 are equal.
- R5: Ordinary comparisons (codes 4, 5) set the invalid flag when either operand is any NaN.
- R6: Every comparison returns 0 when either operand is a NaN.
- R7: A signaling NaN (exponent all ones, mantissa nonzero, mantissa MSB bit 51 clear) on either operand sets the invalid flag for every code. A quiet NaN (bit 51 set) does not set it for codes 0 to 3, 6 and 7.
- R8: `resFlags` is ordered {invalid, divide-by-zero, overflow, underflow, inexact}, with invalid at bit 4. Bits 3:0 are always zero.
- R9: With the output register enabled (default), results appear one clock after the inputs. While `rstN` is low all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rstN | input | 1 | Asynchronous active-low reset |
| opSel | input | 3 | Operation code |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| resData | output | 64 | Selected min/max value, zero for compares |
| resCmp | output | 1 | Compare result, zero for min/max |
| resFlags | output | 5 | Exception flags, invalid in bit 4 |

## Verification
The hardest situations to reach are NaNs with a chosen quiet bit, and equal or sign-differing zeros. Uniform random 64-bit operands almost never produce either. The stimulus therefore draws each operand from weighted classes: random bits, signed zeros, infinities, quiet NaNs, signaling NaNs with a forced nonzero payload, and small integers. The second operand is sometimes a copy or sign-flip of the first. Directed vectors then pin the -0/+0 order, the one-NaN and two-NaN cases, and the quiet-versus-ordinary invalid split.

// File: rtl/fpmm_pkg.sv
package fpmm_pkg;

  typedef enum logic [2:0] {
    OP_MIN  = 3'd0,
    OP_MAX  = 3'd1,
    OP_MINP = 3'd2,
    OP_MAXP = 3'd3,
    OP_LT   = 3'd4,
    OP_LE   = 3'd5,
    OP_LTQ  = 3'd6,
    OP_LEQ  = 3'd7
  } fpmmOp_e;

  // strobes from control to datapath
  typedef struct packed {
    logic selCmp;   // compare family
    logic pickMax;  // max instead of min
    logic nanProp;  // any NaN gives canonical NaN
    logic orEqual;  // less-or-equal instead of less-than
    logic quiet;    // only signaling NaN is invalid
  } fpmmCtl_s;

endpackage

// File: rtl/fpmm_ctrl.sv
module fpmm_ctrl
  import fpmm_pkg::*;
(
  input  logic [2:0] opSel,
  output fpmmCtl_s   ctl
);

  fpmmOp_e op;

  always_comb begin
    op  = fpmmOp_e'(opSel);
    ctl = '0;
    unique case (op)
      OP_MIN:  ctl = '{selCmp: 1'b0, pickMax: 1'b0, nanProp: 1'b0, orEqual: 1'b0, quiet: 1'b0};
      OP_MAX:  ctl = '{selCmp: 1'b0, pickMax: 1'b1, nanProp: 1'b0, orEqual: 1'b0, quiet: 1'b0};
      OP_MINP: ctl = '{selCmp: 1'b0, pickMax: 1'b0, nanProp: 1'b1, orEqual: 1'b0, quiet: 1'b0};
      OP_MAXP: ctl = '{selCmp: 1'b0, pickMax: 1'b1, nanProp: 1'b1, orEqual: 1'b0, quiet: 1'b0};
      OP_LT:   ctl = '{selCmp: 1'b1, pickMax: 1'b0, nanProp: 1'b0, orEqual: 1'b0, quiet: 1'b0};
      OP_LE:   ctl = '{selCmp: 1'b1, pickMax: 1'b0, nanProp: 1'b0, orEqual: 1'b1, quiet: 1'b0};
      OP_LTQ:  ctl = '{selCmp: 1'b1, pickMax: 1'b0, nanProp: 1'b0, orEqual: 1'b0, quiet: 1'b1};
      OP_LEQ:  ctl = '{selCmp: 1'b1, pickMax: 1'b0, nanProp: 1'b0, orEqual: 1'b1, quiet: 1'b1};
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/fpmm_classify.sv
module fpmm_classify #(
  parameter int EXP_W = 11,
  parameter int MAN_W = 52,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int MAG_W  = EXP_W + MAN_W
) (
  input  logic [DATA_W-1:0] val,
  output logic              isNan,
  output logic              isSnan,
  output logic              isZero,
  output logic              signBit,
  output logic [MAG_W-1:0]  mag
);

  logic expOnes;
  logic manZero;

  always_comb begin
    signBit = val[DATA_W-1];
    mag     = val[MAG_W-1:0];
    expOnes = &val[MAG_W-1:MAN_W];
    manZero = ~|val[MAN_W-1:0];
    isNan   = expOnes & ~manZero;
    isSnan  = isNan & ~val[MAN_W-1];
    isZero  = ~|mag;
  end

endmodule

// File: rtl/fpmm_dp.sv
module fpmm_dp
  import fpmm_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int FLAG_W  = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int MAG_W  = EXP_W + MAN_W,
  localparam int NOPS   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  fpmmCtl_s          ctl,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] resData,
  output logic              resCmp,
  output logic [FLAG_W-1:0] resFlags
);

  localparam logic [DATA_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic [DATA_W-1:0] opnd   [NOPS];
  logic              nanV   [NOPS];
  logic              snanV  [NOPS];
  logic              zeroV  [NOPS];
  logic              signV  [NOPS];
  logic [MAG_W-1:0]  magV   [NOPS];

  assign opnd[0] = srcA;
  assign opnd[1] = srcB;

  for (genvar i = 0; i < NOPS; i++) begin : g_cls
    fpmm_classify #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_cls (
      .val    (opnd[i]),
      .isNan  (nanV[i]),
      .isSnan (snanV[i]),
      .isZero (zeroV[i]),
      .signBit(signV[i]),
      .mag    (magV[i])
    );
  end

  logic              anyNan, bothNan, anySnan, bothZero;
  logic              magLt, magGt, bitsEq, totalLt;
  logic              ieeeLt, ieeeEq, cmpNext, takeA, invalidNext;
  logic [DATA_W-1:0] pickVal, dataNext;
  logic [FLAG_W-1:0] flagsNext;

  always_comb begin
    anyNan   = nanV[0] | nanV[1];
    bothNan  = nanV[0] & nanV[1];
    anySnan  = snanV[0] | snanV[1];
    bothZero = zeroV[0] & zeroV[1];
    magLt    = magV[0] < magV[1];
    magGt    = magV[0] > magV[1];
    bitsEq   = srcA == srcB;

    // sign-magnitude order where -0 sorts below +0
    if (signV[0] != signV[1]) totalLt = signV[0];
    else if (signV[0])        totalLt = magGt;
    else                      totalLt = magLt;

    ieeeLt = totalLt & ~bothZero;
    ieeeEq = bitsEq | bothZero;
    cmpNext = ~anyNan & (ieeeLt | (ctl.orEqual & ieeeEq));

    takeA = ctl.pickMax ? ~totalLt : totalLt;

    if (bothNan || (ctl.nanProp && anyNan)) pickVal = CANON_NAN;
    else if (nanV[0])                       pickVal = srcB;
    else if (nanV[1])                       pickVal = srcA;
    else                                    pickVal = takeA ? srcA : srcB;

    if (ctl.selCmp) invalidNext = ctl.quiet ? anySnan : anyNan;
    else            invalidNext = anySnan;

    dataNext  = ctl.selCmp ? '0 : pickVal;
    flagsNext = '0;
    flagsNext[FLAG_W-1] = invalidNext;
  end

  if (OUT_REG) begin : g_reg
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        resData  <= '0;
        resCmp   <= 1'b0;
        resFlags <= '0;
      end else begin
        resData  <= dataNext;
        resCmp   <= ctl.selCmp & cmpNext;
        resFlags <= flagsNext;
      end
    end
  end else begin : g_comb
    logic unusedClk;
    assign unusedClk = clk;
    always_comb begin
      resData  = rstN ? dataNext : '0;
      resCmp   = rstN & ctl.selCmp & cmpNext;
      resFlags = rstN ? flagsNext : '0;
    end
  end

endmodule

// File: rtl/fpmm_unit.sv
module fpmm_unit
  import fpmm_pkg::*;
#(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int FLAG_W  = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int DATA_W = 1 + EXP_W + MAN_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  output logic [DATA_W-1:0] resData,
  output logic              resCmp,
  output logic [FLAG_W-1:0] resFlags
);

  fpmmCtl_s ctl;

  fpmm_ctrl u_ctrl (
    .opSel(opSel),
    .ctl  (ctl)
  );

  fpmm_dp #(
    .EXP_W  (EXP_W),
    .MAN_W  (MAN_W),
    .FLAG_W (FLAG_W),
    .OUT_REG(OUT_REG)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ctl     (ctl),
    .srcA    (srcA),
    .srcB    (srcB),
    .resData (resData),
    .resCmp  (resCmp),
    .resFlags(resFlags)
  );

endmodule

// File: rtl/fpmm_unit_chk.sv
module fpmm_unit_chk #(
  parameter int EXP_W   = 11,
  parameter int MAN_W   = 52,
  parameter int FLAG_W  = 5,
  parameter bit OUT_REG = 1'b1,
  localparam int DATA_W = 1 + EXP_W + MAN_W,
  localparam int MAG_W  = EXP_W + MAN_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        opSel,
  input logic [DATA_W-1:0] srcA,
  input logic [DATA_W-1:0] srcB,
  input logic [DATA_W-1:0] resData,
  input logic              resCmp,
  input logic [FLAG_W-1:0] resFlags
);

  localparam logic [DATA_W-1:0] CANON_NAN =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(MAN_W-1){1'b0}}};

  logic              primed;
  logic [2:0]        dOp;
  logic [DATA_W-1:0] dA, dB;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      primed <= 1'b0;
      dOp    <= '0;
      dA     <= '0;
      dB     <= '0;
    end else begin
      primed <= 1'b1;
      dOp    <= opSel;
      dA     <= srcA;
      dB     <= srcB;
    end
  end

  logic [2:0]        oOp;
  logic [DATA_W-1:0] oA, oB;
  logic              live, aNan, bNan, aSig, bSig;

  always_comb begin
    oOp  = OUT_REG ? dOp : opSel;
    oA   = OUT_REG ? dA : srcA;
    oB   = OUT_REG ? dB : srcB;
    live = OUT_REG ? primed : 1'b1;
    aNan = (oA[MAG_W-1:MAN_W] == {EXP_W{1'b1}}) && (oA[MAN_W-1:0] != '0);
    bNan = (oB[MAG_W-1:MAN_W] == {EXP_W{1'b1}}) && (oB[MAN_W-1:0] != '0);
    aSig = aNan && !oA[MAN_W-1];
    bSig = bNan && !oB[MAN_W-1];
  end

  assert_minmax_member_R1: assert property (@(posedge clk) disable iff (!rstN)
    (live && !oOp[2] && !aNan && !bNan) |-> (resData == oA || resData == oB));

  assert_nan_prop_R3: assert property (@(posedge clk) disable iff (!rstN)
    (live && oOp[2:1] == 2'b01 && (aNan || bNan)) |-> resData == CANON_NAN);

  assert_cmp_port_R4: assert property (@(posedge clk) disable iff (!rstN)
    live |-> (oOp[2] ? resData == '0 : !resCmp));

  assert_cmp_nan_zero_R6: assert property (@(posedge clk) disable iff (!rstN)
    (live && oOp[2] && (aNan || bNan)) |-> !resCmp);

  assert_snan_invalid_R7: assert property (@(posedge clk) disable iff (!rstN)
    (live && (aSig || bSig)) |-> resFlags[FLAG_W-1]);

  assert_flags_low_R8: assert property (@(posedge clk) disable iff (!rstN)
    live |-> resFlags[FLAG_W-2:0] == '0);

endmodule

bind fpmm_unit fpmm_unit_chk #(
  .EXP_W(EXP_W), .MAN_W(MAN_W), .FLAG_W(FLAG_W), .OUT_REG(OUT_REG)
) u_chk (
  .clk(clk), .rstN(rstN), .opSel(opSel), .srcA(srcA), .srcB(srcB),
  .resData(resData), .resCmp(resCmp), .resFlags(resFlags)
);

// File: tb/fpmm_unit_tb.sv
`timescale 1ns/1ps
module fpmm_unit_tb;

  localparam logic [63:0] CANON = 64'h7FF8000000000000;
  localparam logic [63:0] PZERO = 64'h0000000000000000;
  localparam logic [63:0] NZERO = 64'h8000000000000000;
  localparam logic [63:0] QNAN  = 64'h7FF8000000001234;
  localparam logic [63:0] SNAN  = 64'h7FF0000000000055;
  localparam logic [63:0] ONE   = 64'h3FF0000000000000;
  localparam logic [63:0] MTWO  = 64'hC000000000000000;
  localparam logic [63:0] PINF  = 64'h7FF0000000000000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  opSel = '0;
  logic [63:0] srcA = '0, srcB = '0;
  logic [63:0] resData;
  logic        resCmp;
  logic [4:0]  resFlags;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  fpmm_unit u_dut (
    .clk(clk), .rstN(rstN), .opSel(opSel), .srcA(srcA), .srcB(srcB),
    .resData(resData), .resCmp(resCmp), .resFlags(resFlags)
  );

  function automatic bit isNanF(logic [63:0] x);
    return (x[62:52] == 11'h7FF) && (x[51:0] != 0);
  endfunction

  function automatic bit isSnanF(logic [63:0] x);
    return isNanF(x) && !x[51];
  endfunction

  // expected {data, cmp, flags}
  function automatic logic [69:0] refModel(logic [2:0] op, logic [63:0] a, logic [63:0] b);
    logic [63:0] d;
    logic c;
    logic inv;
    real ra, rb;
    bit anyN, anyS;
    d = '0; c = 1'b0;
    anyN = isNanF(a) || isNanF(b);
    anyS = isSnanF(a) || isSnanF(b);
    inv = anyS;
    ra = $bitstoreal(a);
    rb = $bitstoreal(b);
    if (op <= 3'd3) begin
      if (isNanF(a) && isNanF(b)) d = CANON;
      else if (op >= 3'd2 && anyN) d = CANON;
      else if (isNanF(a)) d = b;
      else if (isNanF(b)) d = a;
      else if (ra < rb) d = op[0] ? b : a;
      else if (rb < ra) d = op[0] ? a : b;
      else if (a != b) d = (op[0] ^ a[63]) ? a : b; // signed zeros
      else d = a;
    end else begin
      if (!anyN) c = op[0] ? (ra <= rb) : (ra < rb);
      if (!op[1]) inv = anyN;
    end
    return {d, c, inv, 4'b0000};
  endfunction

  task automatic checkOne(logic [2:0] op, logic [63:0] a, logic [63:0] b, string tag);
    logic [69:0] exp;
    @(negedge clk);
    opSel = op; srcA = a; srcB = b;
    exp = refModel(op, a, b);
    @(negedge clk);
    checks++;
    if ({resData, resCmp, resFlags} !== exp) begin
      fails++;
      $display("FAIL %s op=%0d a=%h b=%h actual data=%h cmp=%b flags=%b expected data=%h cmp=%b flags=%b",
               tag, op, a, b, resData, resCmp, resFlags, exp[69:6], exp[5], exp[4:0]);
    end
  endtask

  function automatic logic [63:0] randOperand();
    int unsigned k;
    logic [63:0] v;
    k = $urandom % 8;
    case (k)
      0, 1, 2: v = {$urandom, $urandom};
      3: v = {$urandom % 2 == 0 ? 1'b0 : 1'b1, 63'd0};
      4: v = {$urandom % 2 == 0 ? 1'b0 : 1'b1, 11'h7FF, 52'd0};
      5: v = {1'b0, 11'h7FF, 1'b1, 19'($urandom), 32'($urandom)};
      6: v = {1'b1, 11'h7FF, 1'b0, 19'($urandom), 31'($urandom), 1'b1};
      default: v = $realtobits(real'(int'($urandom % 7) - 3));
    endcase
    return v;
  endfunction

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    opSel = 3'd1; srcA = ONE; srcB = MTWO;
    repeat (3) @(negedge clk);
    checks++;
    if (resData !== '0 || resCmp !== 1'b0 || resFlags !== '0) begin
      fails++;
      $display("FAIL R9 reset: actual data=%h cmp=%b flags=%b expected all zero", resData, resCmp, resFlags);
    end
    rstN = 1'b1;

    // directed corners
    checkOne(3'd0, PZERO, NZERO, "R1 min -0/+0");
    checkOne(3'd1, NZERO, PZERO, "R1 max -0/+0");
    checkOne(3'd1, MTWO, PINF, "R1 max inf");
    checkOne(3'd0, QNAN, ONE, "R2 min one NaN");
    checkOne(3'd1, MTWO, QNAN, "R2 max one NaN");
    checkOne(3'd0, QNAN, SNAN, "R2 min both NaN");
    checkOne(3'd2, QNAN, ONE, "R3 minp qNaN");
    checkOne(3'd3, ONE, MTWO, "R3 maxp ordinary");
    checkOne(3'd4, NZERO, PZERO, "R4 lt zeros");
    checkOne(3'd5, NZERO, PZERO, "R4 le zeros");
    checkOne(3'd4, MTWO, ONE, "R4 lt true");
    checkOne(3'd4, QNAN, ONE, "R5 lt qNaN invalid");
    checkOne(3'd5, ONE, QNAN, "R5 le qNaN invalid");
    checkOne(3'd7, QNAN, QNAN, "R6 leq NaN zero");
    checkOne(3'd6, QNAN, ONE, "R7 ltq qNaN quiet");
    checkOne(3'd6, ONE, SNAN, "R7 ltq sNaN invalid");
    checkOne(3'd1, SNAN, ONE, "R7 max sNaN invalid");
    checkOne(3'd0, ONE, QNAN, "R7 min qNaN quiet");

    // back-to-back: one-cycle latency
    @(negedge clk);
    opSel = 3'd0; srcA = ONE; srcB = MTWO;
    @(negedge clk);
    opSel = 3'd4; srcA = ONE; srcB = MTWO;
    checks++;
    if (resData !== MTWO || resCmp !== 1'b0) begin
      fails++;
      $display("FAIL R9 latency: actual data=%h cmp=%b expected data=%h cmp=0", resData, resCmp, MTWO);
    end

    for (int i = 0; i < 3000; i++) begin
      logic [63:0] a, b;
      logic [2:0] op;
      a = randOperand();
      case ($urandom % 4)
        0: b = a;
        1: b = {~a[63], a[62:0]};
        default: b = randOperand();
      endcase
      op = 3'($urandom);
      checkOne(op, a, b, "R1 R2 R3 R4 R5 R6 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule